// File: doc/BRIEF.md
# Transceiver Reset Retry Sequencer

This block sits on a free-running system clock and owns the combined transmit and receive reset of one high-speed serial transceiver subsystem. After power-up the reset is released, and it stays released while the reference clock source is being configured. When the reference is reported stable, the block issues one reset pulse of fixed width. It then watches the clock that the subsystem generates. If that clock produces no activity within a retry interval, the block pulses reset again, and it keeps doing so until the clock appears.

Activity is sensed by a toggle flop clocked by the monitored clock. The flop's output is passed through a synchronizer into the system domain, where any change counts as activity. Once the clock is seen, retries stop and an alive flag rises. If the clock later goes quiet for a full detection window, the flag drops and the retry loop starts over. A retry limit raises a sticky failure flag. A build parameter chooses whether retries then stop or continue. The reference-stable input is read only in the power-up state. Only this one subsystem's reset is driven.

Top module: `lane_rst_seq`

## Requirements
- R1: While `rst_sys` is sampled high, and on the first cycle after it, `xcvr_rst`, `clk_alive` and `retry_fail` are all 0. `rst_sys` is synchronous.
- R2: In the power-up state with `ref_ok` low, `xcvr_rst` stays 0 indefinitely.
- R3: `ref_ok` high in the power-up state starts exactly one reset pulse, which is `xcvr_rst` high for `PULSE_CYC` consecutive cycles.
- R4: After a pulse, if no activity arrives, `xcvr_rst` stays low for exactly `REF_KHZ*RETRY_US/1000` cycles and then pulses again. The defaults give 20 ms at 156.25 MHz.
- R5: Every pulse lasts exactly `PULSE_CYC` cycles unless `rst_sys` cuts it short.
- R6: Activity seen while waiting after a pulse raises `clk_alive`. No further pulse is issued while activity continues, and `xcvr_rst` is 0 whenever `clk_alive` is 1.
- R7: With `clk_alive` high, `WINDOW_CYC` cycles without activity drop `clk_alive` and start a new pulse in the same cycle.
- R8: When the wait after the `MAX_RETRY`-th retry pulse expires, `retry_fail` rises. With `CONT_RETRY`=0 the reset then stays low and no more pulses follow. A run therefore has 1+`MAX_RETRY` pulses.
- R9: With `CONT_RETRY`=1, `retry_fail` rises in the same cycle as a new pulse begins, and pulses continue after that.
- R10: `retry_fail` stays set until `rst_sys`. `rst_sys` clears it and the retry count, and the block returns to the power-up state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_sys | input | 1 | Free-running system clock |
| rst_sys | input | 1 | Synchronous global reset, active high |
| ref_ok | input | 1 | Reference clock source reports stable |
| mon_clk | input | 1 | Clock generated by the subsystem, being watched |
| xcvr_rst | output | 1 | Combined transmit/receive reset to the subsystem |
| clk_alive | output | 1 | Monitored clock detected as running |
| retry_fail | output | 1 | Sticky: retry limit reached |

## Verification
The retry-limit decision and the end of a retry interval fall in the same cycle: the expiry that hits the limit both sets the failure flag and chooses between halting and pulsing again. This is provoked by holding the monitored clock still through all retries, with two copies of the block, one halting and one continuous, fed identical stimulus. At the sample where the flag first appears, the continuous copy must already be in a new pulse, while the halting copy must show the flag with its reset released. Pulse widths and gaps are checked against a scoreboard of expected lengths throughout.

// File: rtl/lrs_pkg.sv
package lrs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PULSE = 3'd1,
    ST_WATCH = 3'd2,
    ST_ALIVE = 3'd3,
    ST_HALT  = 3'd4
  } lrs_state_e;

  // Cycles in an interval given a clock rate in kHz and a length in microseconds.
  function automatic int unsigned interval_cycles(int unsigned khz, int unsigned us);
    longint unsigned prod;
    prod = longint'(khz) * longint'(us);
    return int'(prod / 1000);
  endfunction

  function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/lrs_act_detect.sv
module lrs_act_detect #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic mon_clk,
  input  logic clk,
  input  logic rst,
  output logic act
);
  localparam int unsigned SH_W = SYNC_STAGES + 1;

  logic            tog;
  logic [SH_W-1:0] sh;

  // Divide-by-two in the watched domain: any running clock flips this bit.
  always_ff @(posedge mon_clk) tog <= ~tog;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[SH_W-2:0], tog};
  end

  // A change between the last two synchronized samples is one activity event.
  assign act = sh[SH_W-1] ^ sh[SH_W-2];
endmodule

// File: rtl/lrs_seq_fsm.sv
module lrs_seq_fsm
  import lrs_pkg::*;
#(
  parameter int unsigned PULSE_CYC  = 1024,
  parameter int unsigned RETRY_CYC  = 3125000,
  parameter int unsigned WINDOW_CYC = 4096,
  parameter int unsigned MAX_RETRY  = 8,
  parameter bit          CONT_RETRY = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_ok,
  input  logic act,
  output logic rst_o,
  output logic alive_o,
  output logic fail_o
);
  localparam int unsigned CNT_W = $clog2(max3(PULSE_CYC, RETRY_CYC, WINDOW_CYC) + 1);
  localparam int unsigned TRY_W = $clog2(MAX_RETRY + 1) + 1;

  lrs_state_e       st;
  logic [CNT_W-1:0] cnt;
  logic [TRY_W-1:0] tries;

  // Named events for the assertions and for reading the state machine.
  logic pulse_end, watch_timeout, alive_lost, limit_hit;
  assign pulse_end     = (st == ST_PULSE) && (cnt == CNT_W'(PULSE_CYC - 1));
  assign watch_timeout = (st == ST_WATCH) && !act && (cnt == CNT_W'(RETRY_CYC - 1));
  assign alive_lost    = (st == ST_ALIVE) && !act && (cnt == CNT_W'(WINDOW_CYC - 1));
  assign limit_hit     = watch_timeout && (tries == TRY_W'(MAX_RETRY));

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= ST_IDLE;
      cnt   <= '0;
      tries <= '0;
      fail_o <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: begin
          cnt <= '0;
          if (ref_ok) st <= ST_PULSE;
        end
        ST_PULSE: begin
          if (pulse_end) begin
            st  <= ST_WATCH;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
        end
        ST_WATCH: begin
          if (act) begin
            st    <= ST_ALIVE;
            cnt   <= '0;
            tries <= '0;
          end else if (watch_timeout) begin
            cnt <= '0;
            if (limit_hit) begin
              fail_o <= 1'b1;
              st     <= CONT_RETRY ? ST_PULSE : ST_HALT;
            end else begin
              tries <= tries + 1'b1;
              st    <= ST_PULSE;
            end
          end else cnt <= cnt + 1'b1;
        end
        ST_ALIVE: begin
          if (act) cnt <= '0;
          else if (alive_lost) begin
            st  <= ST_PULSE;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
        end
        default: st <= ST_HALT;
      endcase
    end
  end

  assign rst_o   = (st == ST_PULSE);
  assign alive_o = (st == ST_ALIVE);

  // Run length of the reset output, kept apart from the state counter.
  logic [31:0] hi_run;
  always_ff @(posedge clk) begin
    if (rst || !rst_o) hi_run <= '0;
    else               hi_run <= hi_run + 1;
  end

  assert_pulse_width_R5: assert property (@(posedge clk) disable iff (rst)
    ($fell(rst_o) && !$past(rst)) |-> (hi_run == PULSE_CYC));

  assert_quiet_idle_R2: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE && !ref_ok) |=> !rst_o);

  assert_alive_released_R6: assert property (@(posedge clk) disable iff (rst)
    alive_o |-> !rst_o);

  assert_fail_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    fail_o |=> fail_o);

  generate
    if (CONT_RETRY) begin : g_cont
      assert_fail_with_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(fail_o) |-> rst_o);
    end else begin : g_halt
      assert_halt_released_R8: assert property (@(posedge clk) disable iff (rst)
        fail_o |-> (!rst_o && !alive_o));
    end
  endgenerate
endmodule

// File: rtl/lane_rst_seq.sv
module lane_rst_seq
  import lrs_pkg::*;
#(
  parameter int unsigned REF_KHZ     = 156250,
  parameter int unsigned RETRY_US    = 20000,
  parameter int unsigned PULSE_CYC   = 1024,
  parameter int unsigned WINDOW_CYC  = 4096,
  parameter int unsigned MAX_RETRY   = 8,
  parameter bit          CONT_RETRY  = 1'b1,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_sys,
  input  logic rst_sys,
  input  logic ref_ok,
  input  logic mon_clk,
  output logic xcvr_rst,
  output logic clk_alive,
  output logic retry_fail
);
  localparam int unsigned RETRY_CYC = interval_cycles(REF_KHZ, RETRY_US);

  logic act;

  lrs_act_detect #(.SYNC_STAGES(SYNC_STAGES)) u_act (
    .mon_clk (mon_clk),
    .clk     (clk_sys),
    .rst     (rst_sys),
    .act     (act)
  );

  lrs_seq_fsm #(
    .PULSE_CYC  (PULSE_CYC),
    .RETRY_CYC  (RETRY_CYC),
    .WINDOW_CYC (WINDOW_CYC),
    .MAX_RETRY  (MAX_RETRY),
    .CONT_RETRY (CONT_RETRY)
  ) u_fsm (
    .clk     (clk_sys),
    .rst     (rst_sys),
    .ref_ok  (ref_ok),
    .act     (act),
    .rst_o   (xcvr_rst),
    .alive_o (clk_alive),
    .fail_o  (retry_fail)
  );
endmodule

// File: tb/lane_rst_seq_bench.sv
`timescale 1ns/1ps
module lane_rst_seq_bench;
  localparam int TB_KHZ = 1000;
  localparam int TB_US  = 40;
  localparam int P      = 8;
  localparam int WIN    = 16;
  localparam int MAXR   = 2;
  localparam int GAP    = TB_KHZ * TB_US / 1000;

  logic clk = 1'b0, mon_clk = 1'b0, mon_en = 1'b0;
  logic rst_sys = 1'b1, ref_ok = 1'b0;
  logic xr_h, al_h, fl_h, xr_c, al_c, fl_c;
  int   errors = 0, checks = 0, cyc = 0;

  always #5 clk = ~clk;
  always #3.5 mon_clk = mon_en ? ~mon_clk : 1'b0;

  lane_rst_seq #(.REF_KHZ(TB_KHZ), .RETRY_US(TB_US), .PULSE_CYC(P), .WINDOW_CYC(WIN),
                 .MAX_RETRY(MAXR), .CONT_RETRY(1'b0)) u_lane_rst_seq (
    .clk_sys(clk), .rst_sys(rst_sys), .ref_ok(ref_ok), .mon_clk(mon_clk),
    .xcvr_rst(xr_h), .clk_alive(al_h), .retry_fail(fl_h));

  lane_rst_seq #(.REF_KHZ(TB_KHZ), .RETRY_US(TB_US), .PULSE_CYC(P), .WINDOW_CYC(WIN),
                 .MAX_RETRY(MAXR), .CONT_RETRY(1'b1)) u_lane_rst_seq_cont (
    .clk_sys(clk), .rst_sys(rst_sys), .ref_ok(ref_ok), .mon_clk(mon_clk),
    .xcvr_rst(xr_c), .clk_alive(al_c), .retry_fail(fl_c));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Scoreboard: each item is the expected length of the next run of xcvr_rst
  // (alternating low gap, high pulse); -1 means the length is not judged.
  typedef struct { int len; string tag; } exp_t;
  exp_t q[$];
  task automatic push(input int len, input string tag);
    exp_t e;
    e.len = len; e.tag = tag;
    q.push_back(e);
  endtask

  logic prev_xr = 1'b0;
  int   run = 0;
  always @(negedge clk) begin
    if (xr_h !== prev_xr) begin
      if (q.size() == 0) chk(1'b0, "R2 unexpected reset edge", int'(xr_h), int'(prev_xr));
      else begin
        exp_t e;
        e = q.pop_front();
        if (e.len >= 0) chk(run == e.len, e.tag, run, e.len);
      end
      run = 1;
    end else run++;
    prev_xr = xr_h;
  end

  // Same-cycle judgement of the retry-limit decision in both variants.
  logic cf_prev = 1'b0;
  int   cont_rises = 0;
  logic xc_prev = 1'b0;
  always @(negedge clk) begin
    if (fl_c && !cf_prev) begin
      chk(xr_c == 1'b1, "R9 pulse starts with fail", int'(xr_c), 1);
      chk(fl_h == 1'b1 && xr_h == 1'b0, "R8 fail with reset released",
          int'({fl_h, xr_h}), 2);
    end
    if (fl_c && xr_c && !xc_prev) cont_rises++;
    cf_prev = fl_c;
    xc_prev = xr_c;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000) begin
      chk(1'b0, "watchdog", cyc, 5000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    chk({xr_h, al_h, fl_h} == 3'b000, "R1 outputs during reset", int'({xr_h, al_h, fl_h}), 0);
    rst_sys = 1'b0;
    @(negedge clk);
    chk({xr_h, al_h, fl_h} == 3'b000, "R1 outputs after reset", int'({xr_h, al_h, fl_h}), 0);
    repeat (60) @(negedge clk);
    chk(xr_h == 1'b0, "R2 no pulse before ref_ok", int'(xr_h), 0);

    // Clock absent: initial pulse plus MAXR retries, then halt.
    push(-1, "R3 lead gap"); push(P, "R3 first pulse width");
    push(GAP, "R4 retry gap"); push(P, "R5 retry pulse width");
    push(GAP, "R4 retry gap"); push(P, "R5 retry pulse width");
    ref_ok = 1'b1;
    repeat (3 * (P + GAP) + 20) @(negedge clk);
    chk(fl_h == 1'b1, "R8 fail flag set", int'(fl_h), 1);
    chk(xr_h == 1'b0, "R8 reset released after halt", int'(xr_h), 0);
    chk(q.size() == 0, "R8 all pulses seen", q.size(), 0);
    repeat (150) @(negedge clk);
    chk(fl_h == 1'b1, "R10 fail stays set", int'(fl_h), 1);
    chk(cont_rises >= 2, "R9 retries continue after fail", cont_rises, 2);

    // Global reset, then a running clock.
    mon_en = 1'b1;
    push(-1, "R10 lead gap"); push(P, "R10 pulse after reset");
    rst_sys = 1'b1;
    repeat (2) @(negedge clk);
    chk(fl_h == 1'b0 && fl_c == 1'b0, "R10 fail cleared", int'({fl_h, fl_c}), 0);
    rst_sys = 1'b0;
    repeat (100) @(negedge clk);
    chk(al_h == 1'b1, "R6 alive raised", int'(al_h), 1);
    chk(q.size() == 0, "R6 single pulse", q.size(), 0);
    repeat (200) @(negedge clk);
    chk(al_h == 1'b1 && xr_h == 1'b0, "R6 no retry while alive", int'({al_h, xr_h}), 2);

    // Clock stops: alive drops and a pulse starts in the same cycle.
    push(-1, "R7 lead gap"); push(P, "R7 pulse width");
    mon_en = 1'b0;
    for (int i = 0; i < 100 && al_h; i++) @(negedge clk);
    chk(al_h == 1'b0, "R7 alive dropped", int'(al_h), 0);
    chk(xr_h == 1'b1, "R7 pulse with alive loss", int'(xr_h), 1);
    for (int i = 0; i < 50 && xr_h; i++) @(negedge clk);
    mon_en = 1'b1;
    repeat (60) @(negedge clk);
    chk(al_h == 1'b1, "R6 alive after restart", int'(al_h), 1);
    chk(q.size() == 0, "R7 expected pulses seen", q.size(), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule